// File: doc/BRIEF.md
# Word Stack Push/Pop Sequencer

This block moves 16-bit words onto and off a stack kept in a byte-wide memory. It holds the stack pointer. On each request it forms the physical byte address from a 16-bit segment value and the pointer, then carries the word through the memory port as two byte transfers in a fixed order. A push stores the word below the current pointer and lowers the pointer by two. A pop fetches the word at the current pointer and raises the pointer by two.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid`, `req_pop` and `req_wdata` steady until that edge. `req_ready` stays low from the accepting edge until the word operation finishes, and also while a pointer load is offered. Completion is a one-cycle `rsp_valid` pulse, and this pulse has no back-pressure: a pop result is valid only while `rsp_valid` is high. The memory port assumes combinational read data. `mem_rdata` must reflect `mem_addr` within the same cycle in which `mem_en` is high and `mem_we` is low.

Top module: `word_stack_seq`

## Requirements
- R1: While reset is held and after its release, `sp_out` is 0, `req_ready` is 1, and `rsp_valid` and `mem_en` are 0.
- R2: A push drives two write cycles. The first writes bits 15:8 of the word at offset SP-1, and the second writes bits 7:0 at offset SP-2.
- R3: A completed push leaves `sp_out` two lower than before the request.
- R4: A pop drives two read cycles, first at offset SP and then at SP+1. It returns {byte read at SP+1, byte read at SP} on `rsp_rdata`.
- R5: A completed pop leaves `sp_out` two higher than before the request.
- R6: Every memory address equals (segment × 16 + offset) modulo 2^20. The segment used is the `seg_base` value sampled on the accepting edge, and later changes to `seg_base` do not affect the operation in flight.
- R7: Offsets and the pointer wrap modulo 65536. For example, a push from SP=0 writes offsets 0xFFFF and 0xFFFE.
- R8: `mem_en` is high for exactly the two cycles after the accepting edge. `rsp_valid` is high for the single cycle that follows them, and the pointer update is visible in that same cycle.
- R9: While an operation is in progress, `req_ready` is low, and `ptr_ld_en` has no effect on the pointer.
- R10: When the block is idle, `ptr_ld_en` loads `ptr_ld_val` into the pointer on the next edge. In that cycle `req_ready` is low, so a simultaneous request is not taken.
- R11: Outside the two byte cycles, `mem_en` and `mem_we` are low, and `mem_we` is never high without `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_base | input | 16 | Stack segment value, sampled when a request is taken |
| ptr_ld_en | input | 1 | Load the pointer (honoured only when idle) |
| ptr_ld_val | input | 16 | Value to load into the pointer |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_wdata | input | 16 | Word to push |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Popped word, valid with `rsp_valid` after a pop |
| sp_out | output | 16 | Current stack pointer |
| mem_en | output | 1 | Byte memory access this cycle |
| mem_we | output | 1 | Byte access is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read (combinational) |

## Verification
The bound checker watches several properties on every cycle:
- the two-cycle shape of each memory burst and the single-cycle completion pulse;
- the pointer moving by exactly two in the right direction at completion;
- the pointer staying frozen and `req_ready` staying low during a burst;
- `mem_we` never appearing without `mem_en`.

Byte order, address formation from the captured segment, offset wrap at both ends of the 64 KiB range, LIFO data return and load-versus-request priority all depend on stimulus. Only the bench's scenarios show them, by comparing the design against its reference model every cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } stk_phase_e;
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [OFS_W-1:0] ld_val,
  input  logic             adj_en,
  input  logic             adj_down,
  output logic [OFS_W-1:0] ptr
);
  localparam logic [OFS_W-1:0] STEP = OFS_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (ld_en)  ptr <= ld_val;
    else if (adj_en) ptr <= adj_down ? ptr - STEP : ptr + STEP;
  end
endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [OFS_W-1:0]           seg,
  input  logic [OFS_W-1:0]           ofs,
  output logic [OFS_W+SEG_SHIFT-1:0] addr
);
  localparam int ADDR_W = OFS_W + SEG_SHIFT;

  // Sum is truncated to ADDR_W bits, so it wraps modulo 2^ADDR_W.
  assign addr = {seg, {SEG_SHIFT{1'b0}}} + ADDR_W'(ofs);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_pop,
  input  logic [2*BYTE_W-1:0] req_wdata,
  input  logic                ptr_ld_en,
  input  logic [OFS_W-1:0]    seg_in,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                req_ready,
  output stk_phase_e          phase,
  output logic                pop_q,
  output logic [2*BYTE_W-1:0] wdata_q,
  output logic [OFS_W-1:0]    seg_q,
  output logic                rsp_valid,
  output logic [2*BYTE_W-1:0] rsp_rdata
);
  logic              accept;
  logic [BYTE_W-1:0] lo_q;

  // A pointer load wins over a request in the same idle cycle.
  assign req_ready = (phase == PH_IDLE) && !ptr_ld_en;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      pop_q     <= 1'b0;
      wdata_q   <= '0;
      seg_q     <= '0;
      lo_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (phase == PH_SECOND);
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase   <= PH_FIRST;
          pop_q   <= req_pop;
          wdata_q <= req_wdata;
          seg_q   <= seg_in;
        end
        PH_FIRST: begin
          if (pop_q) lo_q <= mem_rdata;
          phase <= PH_SECOND;
        end
        PH_SECOND: begin
          if (pop_q) rsp_rdata <= {mem_rdata, lo_q};
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/word_stack_seq.sv
module word_stack_seq
  import stk_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int BYTE_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OFS_W-1:0]          seg_base,
  input  logic                      ptr_ld_en,
  input  logic [OFS_W-1:0]          ptr_ld_val,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_pop,
  input  logic [2*BYTE_W-1:0]       req_wdata,
  output logic                      rsp_valid,
  output logic [2*BYTE_W-1:0]       rsp_rdata,
  output logic [OFS_W-1:0]          sp_out,
  output logic                      mem_en,
  output logic                      mem_we,
  output logic [OFS_W+SEG_SHIFT-1:0] mem_addr,
  output logic [BYTE_W-1:0]         mem_wdata,
  input  logic [BYTE_W-1:0]         mem_rdata
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);
  localparam logic [OFS_W-1:0] TWO = OFS_W'(2);

  stk_phase_e          phase;
  logic                pop_q;
  logic [2*BYTE_W-1:0] wdata_q;
  logic [OFS_W-1:0]    seg_q;
  logic [OFS_W-1:0]    ofs;
  logic                idle;

  assign idle = (phase == PH_IDLE);

  stk_ctrl #(.OFS_W(OFS_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_pop(req_pop), .req_wdata(req_wdata),
    .ptr_ld_en(ptr_ld_en), .seg_in(seg_base), .mem_rdata(mem_rdata),
    .req_ready(req_ready), .phase(phase), .pop_q(pop_q),
    .wdata_q(wdata_q), .seg_q(seg_q),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  stk_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ptr_ld_en && idle), .ld_val(ptr_ld_val),
    .adj_en(phase == PH_SECOND), .adj_down(!pop_q),
    .ptr(sp_out)
  );

  // Byte offset for each phase. Push goes high byte first, below SP.
  // Pop goes low byte first, at and above SP.
  always_comb begin
    unique case (phase)
      PH_FIRST:  ofs = pop_q ? sp_out : sp_out - ONE;
      PH_SECOND: ofs = pop_q ? sp_out + ONE : sp_out - TWO;
      default:   ofs = sp_out;
    endcase
  end

  stk_addr_gen #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
    .seg(seg_q), .ofs(ofs), .addr(mem_addr)
  );

  assign mem_en    = !idle;
  assign mem_we    = mem_en && !pop_q;
  assign mem_wdata = (phase == PH_FIRST) ? wdata_q[2*BYTE_W-1:BYTE_W]
                                         : wdata_q[BYTE_W-1:0];
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [OFS_W-1:0] sp_out,
  input logic             mem_en,
  input logic             mem_we
);
  localparam logic [OFS_W-1:0] TWO = OFS_W'(2);

  assert_burst_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en) |=> mem_en);
  assert_burst_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |=> (!mem_en && rsp_valid));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(mem_we)) |-> (sp_out == $past(sp_out) - TWO));
  assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(mem_we)) |-> (sp_out == $past(sp_out) + TWO));
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);
  assert_ptr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> $stable(sp_out));
  assert_we_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> !mem_we);
endmodule

bind word_stack_seq stk_checker #(.OFS_W(OFS_W)) u_stk_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sp_out(sp_out), .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/test_word_stack_seq.sv
`timescale 1ns/1ps
module test_word_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] seg_base, ptr_ld_val, req_wdata;
  logic        ptr_ld_en, req_valid, req_pop;
  logic        req_ready, rsp_valid, mem_en, mem_we;
  logic [15:0] rsp_rdata, sp_out;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0] bmem [0:4095];
  assign mem_rdata = bmem[mem_addr[11:0]];

  always #2.5 clk = ~clk;

  word_stack_seq i_word_stack_seq (
    .clk(clk), .rst_n(rst_n), .seg_base(seg_base),
    .ptr_ld_en(ptr_ld_en), .ptr_ld_val(ptr_ld_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_pop(req_pop),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sp_out(sp_out), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;
  string tag = "R1";

  // Behavioural reference model state.
  int          m_phase = 0;
  logic [15:0] m_sp = 0, m_seg = 0, m_data = 0, m_rsp = 0;
  logic [7:0]  m_lo = 0;
  bit          m_pop = 0, m_rv = 0;

  task automatic check(string t, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
    end
  endtask

  function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
    return {s, 4'b0} + {4'b0, o};
  endfunction

  function automatic logic [15:0] m_ofs();
    if (m_phase == 1) return m_pop ? m_sp : m_sp - 16'd1;
    if (m_phase == 2) return m_pop ? m_sp + 16'd1 : m_sp - 16'd2;
    return m_sp;
  endfunction

  task automatic compare();
    logic [19:0] a;
    a = phys(m_seg, m_ofs());
    check(tag, "req_ready", req_ready, (m_phase == 0) && !ptr_ld_en);
    check(tag, "rsp_valid", rsp_valid, m_rv);
    check(tag, "sp_out", sp_out, m_sp);
    check(tag, "mem_en", mem_en, m_phase != 0);
    check(tag, "mem_we", mem_we, (m_phase != 0) && !m_pop);
    if (m_phase != 0) check(tag, "mem_addr", mem_addr, a);
    if (m_phase != 0 && !m_pop)
      check(tag, "mem_wdata", mem_wdata, (m_phase == 1) ? m_data[15:8] : m_data[7:0]);
    if (m_rv && m_pop) check(tag, "rsp_rdata", rsp_rdata, m_rsp);
  endtask

  // Advance the model over the next edge with the inputs now held.
  // Then compare at the following falling edge and apply memory writes.
  task automatic step();
    logic [19:0] a;
    bit rv_n;
    a    = phys(m_seg, m_ofs());
    rv_n = (m_phase == 2);
    case (m_phase)
      0: if (ptr_ld_en) m_sp = ptr_ld_val;
         else if (req_valid) begin
           m_pop = req_pop; m_data = req_wdata; m_seg = seg_base; m_phase = 1;
         end
      1: begin if (m_pop) m_lo = bmem[a[11:0]]; m_phase = 2; end
      default: begin
        if (m_pop) m_rsp = {bmem[a[11:0]], m_lo};
        m_sp = m_pop ? m_sp + 16'd2 : m_sp - 16'd2;
        m_phase = 0;
      end
    endcase
    m_rv = rv_n;
    @(negedge clk);
    compare();
    if (mem_en && mem_we) bmem[mem_addr[11:0]] = mem_wdata;
  endtask

  task automatic issue(bit pop, logic [15:0] d);
    req_valid = 1; req_pop = pop; req_wdata = d;
    step();
    req_valid = 0;
    repeat (3) step();
  endtask

  task automatic load(logic [15:0] v);
    ptr_ld_en = 1; ptr_ld_val = v; step(); ptr_ld_en = 0;
  endtask

  initial begin : watchdog
    #(5.0 * 20000);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] sp0;
    for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
    rst_n = 0; seg_base = 16'h0000; ptr_ld_en = 0; ptr_ld_val = 0;
    req_valid = 0; req_pop = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", "reset req_ready", req_ready, 1);
    check("R1", "reset rsp_valid", rsp_valid, 0);
    check("R1", "reset sp_out", sp_out, 0);
    check("R1", "reset mem_en", mem_en, 0);
    rst_n = 1;
    step(); step();

    tag = "R10";  // load and request together: load wins, request waits
    ptr_ld_en = 1; ptr_ld_val = 16'h0100; req_valid = 1; req_pop = 0; req_wdata = 16'h7777;
    step();
    ptr_ld_en = 0; req_valid = 0;
    step();
    check("R10", "loaded pointer", sp_out, 16'h0100);

    tag = "R2"; seg_base = 16'h0010;
    sp0 = sp_out;
    issue(0, 16'hA55A);
    check("R2", "high byte at SP-1", bmem[phys(16'h0010, sp0 - 1) & 20'hFFF], 8'hA5);
    check("R2", "low byte at SP-2", bmem[phys(16'h0010, sp0 - 2) & 20'hFFF], 8'h5A);
    tag = "R3";
    check("R3", "sp after push", sp_out, sp0 - 16'd2);

    tag = "R6";  // segment changes after acceptance must not matter
    req_valid = 1; req_pop = 0; req_wdata = 16'h1234; seg_base = 16'h0010;
    step();
    req_valid = 0; seg_base = 16'h0055;
    repeat (3) step();
    seg_base = 16'h0010;

    tag = "R4";
    issue(1, 16'h0000);
    check("R4", "pop returns last push", rsp_rdata, 16'h1234);
    tag = "R5";
    sp0 = sp_out;
    issue(1, 16'h0000);
    check("R4", "second pop returns first push", rsp_rdata, 16'hA55A);
    check("R5", "sp after pop", sp_out, sp0 + 16'd2);

    tag = "R8";  // request held valid: back-to-back pushes
    req_valid = 1; req_pop = 0; req_wdata = 16'hC0DE;
    repeat (9) step();
    req_valid = 0;
    repeat (3) step();

    tag = "R9";  // load offered mid-burst is ignored
    req_valid = 1; req_pop = 1; step(); req_valid = 0;
    ptr_ld_en = 1; ptr_ld_val = 16'h0BAD; step(); step();
    ptr_ld_en = 0; step();
    check("R9", "pointer not loaded while busy", sp_out == 16'h0BAD, 0);

    tag = "R7";
    load(16'h0000);
    issue(0, 16'hBEEF);
    check("R7", "sp wraps below zero", sp_out, 16'hFFFE);
    issue(1, 16'h0000);
    check("R7", "pop across wrap", rsp_rdata, 16'hBEEF);
    load(16'hFFFF);
    issue(1, 16'h0000);
    check("R7", "sp wraps above top", sp_out, 16'h0001);

    tag = "R6"; seg_base = 16'hFFF0;  // physical address wraps at 2^20
    load(16'h0200);
    issue(0, 16'h4321);
    issue(1, 16'h0000);
    check("R6", "pop through wrapped address", rsp_rdata, 16'h4321);

    tag = "R11";
    repeat (4) step();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule